// File: doc/BRIEF.md
# Reference clock divider with settle flag

The block divides a reference clock by an integer ratio held in a single 32-bit control word. A write port updates the word and a combinational read port returns it together with a live settle flag. A new ratio is written into the ratio field and takes effect only when the same write also sets the apply strobe. From that write the settle flag drops. It rises again once the output has run four complete periods at the new ratio. The apply strobe reads back as 1 until then.

The output can be stopped with an enable bit. Enable changes act only at the start of a period, so no pulse is ever cut short. A second bit holds the divided domain in reset. A further bit switches off a reference buffer through a separate active-high pass output. Parameters choose the ratio field width, the bit position of the settle flag, and an optional variant in which the hardware turns the output off while a ratio change is in progress.

Top module: `refclk_divider`

## Requirements
- R1: The control word reads back as: bit 0 enable, bit 1 domain reset, bit 2 apply-pending, bits [4 +: DIV_W] stored ratio field, bit 28 buffer gate, the settle flag at its parameter-chosen position, and all other bits 0. After reset every bit reads 0.
- R2: For an applied ratio N ≥ 2 the output period is N reference cycles, with floor(N/2) cycles high followed by the remaining cycles low. A ratio of 0 or 1 passes the reference clock straight through while enabled.
- R3: Writing the ratio field without the apply strobe (bit 2) stores and reads back the new value, but the output keeps its previous ratio.
- R4: A write with bit 2 set clears the settle flag at the write edge and makes bit 2 read 1. Exactly 4·max(N,1) reference cycles after that edge the flag reads 1 and bit 2 reads 0. The same count applies after reset release.
- R5: With enable at 0 the output stays low. Clearing enable lets a high phase already in progress finish at full length. Setting enable starts output only at the next period start, so the first high pulse has full length.
- R6: While the domain-reset bit is 1 the output is low and the settle flag is 0. After the bit is cleared the flag returns 4·N cycles after the clearing write edge.
- R7: Bit 28 set drives `ref_buf_en_o` low; bit 28 clear drives it high.
- R8: With `LOCK_ALT` = 1 the settle flag reads at bit 27 and bit 31 reads 0. With `LOCK_ALT` = 0 the flag reads at bit 31.
- R9: With `GATE_ON_LOAD` = 1, a write with bit 2 set forces enable to 0. Writes that set enable are ignored until the flag has returned, and are accepted after that.
- R10: The largest field value, 2^DIV_W−1, divides by exactly that value with the same settle count rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 32 | Control word write value |
| rd_data_o | output | 32 | Control word read value with live settle flag |
| clk_div_o | output | 1 | Divided (or passed-through) clock |
| ref_buf_en_o | output | 1 | Reference buffer pass enable (inverse of bit 28) |

## Verification
Stored fields, the apply-pending bit and the dropped settle flag are due on the edge that captures a write, so the bench reads them at the falling edge right after it. The settle flag is checked by counting rising edges from the capture edge until it first reads 1, and the count is compared with 4·max(N,1). Effects of domain reset are due one edge after the bit is stored, and enable changes are due at the next period start, so those checks wait a full cycle or watch for a full pulse. The divided output is sampled at every falling edge and pass-through is sampled 2 ns after a rising edge, so each sample shows one settled cycle.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
   // control word field positions
   localparam int F_EN       = 0;
   localparam int F_DOM_RST  = 1;
   localparam int F_APPLY    = 2;
   localparam int F_RATIO    = 4;
   localparam int F_BUF_GATE = 28;
   localparam int F_LOCK_STD = 31;
   localparam int F_LOCK_ALT = 27;
   localparam int CTL_W      = 32;
   // highest ratio width that keeps the field clear of bit 27
   localparam int RATIO_W_MAX = F_LOCK_ALT - F_RATIO;
endpackage

// File: rtl/refdiv_ctrl_regs.sv
module refdiv_ctrl_regs
   import refdiv_pkg::*;
#(
   parameter int DIV_W        = 8,
   parameter bit LOCK_ALT     = 1'b0,
   parameter bit GATE_ON_LOAD = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_en_i,
   input  logic [CTL_W-1:0] wr_data_i,
   input  logic             lock_i,
   input  logic             lock_set_i,
   output logic             en_o,
   output logic             dom_rst_o,
   output logic             apply_o,
   output logic [DIV_W-1:0] apply_ratio_o,
   output logic             buf_gate_o,
   output logic [CTL_W-1:0] rd_data_o
);
   localparam int LOCK_POS = LOCK_ALT ? F_LOCK_ALT : F_LOCK_STD;

   logic             en_q, dom_rst_q, buf_gate_q, pend_q;
   logic [DIV_W-1:0] ratio_q;
   logic             en_wr;

   assign apply_o       = wr_en_i & wr_data_i[F_APPLY];
   assign apply_ratio_o = wr_data_i[F_RATIO +: DIV_W];

   generate
      if (GATE_ON_LOAD) begin : g_gate_on_load
         // a ratio change darkens the output until the flag returns
         assign en_wr = wr_data_i[F_EN] & ~wr_data_i[F_APPLY] & ~pend_q;
      end else begin : g_free_enable
         assign en_wr = wr_data_i[F_EN];
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q       <= 1'b0;
         dom_rst_q  <= 1'b0;
         buf_gate_q <= 1'b0;
         ratio_q    <= '0;
      end else if (wr_en_i) begin
         en_q       <= en_wr;
         dom_rst_q  <= wr_data_i[F_DOM_RST];
         buf_gate_q <= wr_data_i[F_BUF_GATE];
         ratio_q    <= wr_data_i[F_RATIO +: DIV_W];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         pend_q <= 1'b0;
      else if (apply_o)    pend_q <= 1'b1;
      else if (lock_set_i) pend_q <= 1'b0;
   end

   always_comb begin
      rd_data_o                     = '0;
      rd_data_o[F_EN]               = en_q;
      rd_data_o[F_DOM_RST]          = dom_rst_q;
      rd_data_o[F_APPLY]            = pend_q;
      rd_data_o[F_RATIO +: DIV_W]   = ratio_q;
      rd_data_o[F_BUF_GATE]         = buf_gate_q;
      rd_data_o[LOCK_POS]           = lock_i;
   end

   assign en_o       = en_q;
   assign dom_rst_o  = dom_rst_q;
   assign buf_gate_o = buf_gate_q;

   logic unused_wr_bits;
   assign unused_wr_bits = ^{wr_data_i[CTL_W-1:F_BUF_GATE+1],
                             wr_data_i[F_BUF_GATE-1:F_RATIO+DIV_W],
                             wr_data_i[F_APPLY+1]};

   // R4: pending bit survives until the settle flag is set
   p_pend_kept_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q && !lock_set_i) |=> pend_q);
   // R4: an apply write always marks a change as pending
   p_apply_marks_pend_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      apply_o |=> pend_q);

   generate
      if (GATE_ON_LOAD) begin : g_gate_chk
         // R9: output stays disabled while a change is pending
         p_dark_while_pending_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
            pend_q |-> !en_q);
      end
   endgenerate
endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter #(
   parameter int DIV_W        = 8,
   parameter int LOCK_PERIODS = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             dom_rst_i,
   input  logic             apply_i,
   input  logic [DIV_W-1:0] apply_ratio_i,
   output logic             phase_o,
   output logic             run_o,
   output logic             bypass_o,
   output logic             lock_o,
   output logic             lock_set_o
);
   localparam int PER_W = (LOCK_PERIODS > 2) ? $clog2(LOCK_PERIODS) : 1;
   localparam logic [PER_W-1:0] PER_LAST = PER_W'(LOCK_PERIODS - 1);
   localparam logic [DIV_W-1:0] ONE      = DIV_W'(1);

   logic [DIV_W-1:0] ratio_q, ratio_nx, cnt_q, cnt_nx;
   logic [PER_W-1:0] per_q, per_nx;
   logic             run_q, run_nx, phase_q, phase_nx, lock_q, lock_nx;
   logic             wrap_now, restart, lock_set;

   assign wrap_now = (cnt_q == ratio_q - ONE);
   assign restart  = dom_rst_i | apply_i;

   always_comb begin
      ratio_nx = ratio_q;
      if (apply_i) ratio_nx = (apply_ratio_i == '0) ? ONE : apply_ratio_i;

      if (restart || wrap_now) cnt_nx = '0;
      else                     cnt_nx = cnt_q + ONE;

      run_nx = run_q;
      if (dom_rst_i)          run_nx = 1'b0;
      else if (cnt_nx == '0)  run_nx = en_i;

      phase_nx = !dom_rst_i && run_nx && (cnt_nx < (ratio_nx >> 1));

      lock_set = !lock_q && !restart && wrap_now && (per_q == PER_LAST);

      per_nx = per_q;
      if (restart)                per_nx = '0;
      else if (!lock_q && wrap_now) per_nx = per_q + PER_W'(1);

      lock_nx = lock_q;
      if (restart)       lock_nx = 1'b0;
      else if (lock_set) lock_nx = 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ratio_q <= ONE;
         cnt_q   <= '0;
         per_q   <= '0;
         run_q   <= 1'b0;
         phase_q <= 1'b0;
         lock_q  <= 1'b0;
      end else begin
         ratio_q <= ratio_nx;
         cnt_q   <= cnt_nx;
         per_q   <= per_nx;
         run_q   <= run_nx;
         phase_q <= phase_nx;
         lock_q  <= lock_nx;
      end
   end

   assign phase_o    = phase_q;
   assign run_o      = run_q;
   assign bypass_o   = (ratio_q == ONE);
   assign lock_o     = lock_q;
   assign lock_set_o = lock_set;

   // R4: an apply write drops the settle flag on its own edge
   p_apply_drops_lock_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      apply_i |=> !lock_q);
   // R4: once settled the flag holds until a restart
   p_lock_holds_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lock_q && !restart) |=> lock_q);
   // R6: domain reset silences output and flag
   p_dom_rst_quiet_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      dom_rst_i |=> (!phase_q && !lock_q));
   // R5: a low, disabled output cannot start a pulse
   p_no_rise_when_off_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i && !phase_q) |=> !phase_q);
endmodule

// File: rtl/refdiv_outgate.sv
module refdiv_outgate (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic bypass_i,
   input  logic run_i,
   input  logic phase_i,
   output logic clk_o
);
   logic pass_en_q;

   // captured while the reference is low, so the gated pass path is glitch-free
   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pass_en_q <= 1'b0;
      else         pass_en_q <= run_i & bypass_i;
   end

   assign clk_o = bypass_i ? (clk_i & pass_en_q) : phase_i;
endmodule

// File: rtl/refclk_divider.sv
module refclk_divider
   import refdiv_pkg::*;
#(
   parameter int DIV_W        = 8,
   parameter bit LOCK_ALT     = 1'b0,
   parameter bit GATE_ON_LOAD = 1'b0,
   parameter int LOCK_PERIODS = 4
) (
   input  logic        clk_ref_i,
   input  logic        rst_ni,
   input  logic        wr_en_i,
   input  logic [31:0] wr_data_i,
   output logic [31:0] rd_data_o,
   output logic        clk_div_o,
   output logic        ref_buf_en_o
);
   generate
      if (DIV_W < 1 || DIV_W > RATIO_W_MAX) begin : g_bad_width
         $error("refclk_divider: DIV_W out of range");
      end
      if (LOCK_PERIODS < 2) begin : g_bad_periods
         $error("refclk_divider: LOCK_PERIODS must be at least 2");
      end
   endgenerate

   logic             en, dom_rst, apply, buf_gate;
   logic [DIV_W-1:0] apply_ratio;
   logic             phase, run, bypass, lock, lock_set;

   refdiv_ctrl_regs #(
      .DIV_W        (DIV_W),
      .LOCK_ALT     (LOCK_ALT),
      .GATE_ON_LOAD (GATE_ON_LOAD)
   ) u_regs (
      .clk_i         (clk_ref_i),
      .rst_ni        (rst_ni),
      .wr_en_i       (wr_en_i),
      .wr_data_i     (wr_data_i),
      .lock_i        (lock),
      .lock_set_i    (lock_set),
      .en_o          (en),
      .dom_rst_o     (dom_rst),
      .apply_o       (apply),
      .apply_ratio_o (apply_ratio),
      .buf_gate_o    (buf_gate),
      .rd_data_o     (rd_data_o)
   );

   refdiv_counter #(
      .DIV_W        (DIV_W),
      .LOCK_PERIODS (LOCK_PERIODS)
   ) u_counter (
      .clk_i         (clk_ref_i),
      .rst_ni        (rst_ni),
      .en_i          (en),
      .dom_rst_i     (dom_rst),
      .apply_i       (apply),
      .apply_ratio_i (apply_ratio),
      .phase_o       (phase),
      .run_o         (run),
      .bypass_o      (bypass),
      .lock_o        (lock),
      .lock_set_o    (lock_set)
   );

   refdiv_outgate u_outgate (
      .clk_i    (clk_ref_i),
      .rst_ni   (rst_ni),
      .bypass_i (bypass),
      .run_i    (run),
      .phase_i  (phase),
      .clk_o    (clk_div_o)
   );

   // R7: buffer pass enable is the inverse of the gate bit
   assign ref_buf_en_o = ~buf_gate;
endmodule

// File: tb/refclk_divider_bench.sv
module refclk_divider_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, wr_en_a = 1'b0;
   logic [31:0] wd = '0, wd_a = '0;
   logic [31:0] rd, rd_a;
   logic        co, co_a, bufen, bufen_a;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   refclk_divider u_refclk_divider (
      .clk_ref_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wd),
      .rd_data_o(rd), .clk_div_o(co), .ref_buf_en_o(bufen));

   refclk_divider #(.LOCK_ALT(1'b1), .GATE_ON_LOAD(1'b1)) u_refclk_divider_alt (
      .clk_ref_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en_a), .wr_data_i(wd_a),
      .rd_data_o(rd_a), .clk_div_o(co_a), .ref_buf_en_o(bufen_a));

   // ratio, expected high cycles, expected period (1 = pass-through), settle cycles
   localparam int VEC [7][4] = '{
      '{0, 0, 1, 4}, '{1, 0, 1, 4}, '{2, 1, 2, 8}, '{3, 1, 3, 12},
      '{5, 2, 5, 20}, '{8, 4, 8, 32}, '{255, 127, 255, 1020}};

   task automatic chk(string req, longint act, longint exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(int n, bit en, bit ld, bit dr, bit bg);
      logic [31:0] v;
      v = 32'(n) << 4;
      v[0] = en; v[1] = dr; v[2] = ld; v[28] = bg;
      return v;
   endfunction

   // called at a falling edge; the next rising edge captures the write
   task automatic wr(bit alt, logic [31:0] d);
      if (alt) begin wr_en_a = 1'b1; wd_a = d; end
      else     begin wr_en   = 1'b1; wd   = d; end
      @(negedge clk);
      wr_en = 1'b0; wr_en_a = 1'b0;
   endtask

   task automatic lock_wait(bit alt, output int j);
      j = 0;
      do begin
         @(negedge clk);
         j++;
      end while (!(alt ? rd_a[27] : rd[31]) && j < 3000);
   endtask

   task automatic measure(bit alt, output int hi, output int per);
      int g;
      g = 0; hi = 0; per = 0;
      while ((alt ? co_a : co) !== 1'b0 && g < 2000) begin @(negedge clk); g++; end
      while ((alt ? co_a : co) !== 1'b1 && g < 2000) begin @(negedge clk); g++; end
      while ((alt ? co_a : co) === 1'b1 && g < 2000) begin hi++; per++; @(negedge clk); g++; end
      while ((alt ? co_a : co) === 1'b0 && g < 2000) begin per++; @(negedge clk); g++; end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int j, hi, per, h;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state
      chk("R1 reset word", rd, 0);
      chk("R7 reset buffer pass", bufen, 1);
      chk("R2 reset output", co, 0);
      repeat (10) @(negedge clk);
      chk("R4 settle after reset", rd, 32'h8000_0000);
      chk("R8 alt flag position", rd_a, 32'h0800_0000);

      // table of ratios
      for (int i = 0; i < 7; i++) begin
         int n;
         n = VEC[i][0];
         wr(1'b0, mk(n, 1'b1, 1'b1, 1'b0, 1'b0));
         chk("R4 flag cleared", rd[31], 0);
         chk("R4 apply pending", rd[2], 1);
         chk("R1 ratio field", rd[11:4], n);
         lock_wait(1'b0, j);
         chk(n == 255 ? "R10 settle count" : "R4 settle count", j, VEC[i][3]);
         chk("R4 pending cleared", rd[2], 0);
         if (VEC[i][2] == 1) begin
            for (int k = 0; k < 3; k++) begin
               @(posedge clk); #2;
               chk("R2 pass high", co, 1);
               @(negedge clk);
               chk("R2 pass low", co, 0);
            end
         end else begin
            measure(1'b0, hi, per);
            chk(n == 255 ? "R10 high" : "R2 high", hi, VEC[i][1]);
            chk(n == 255 ? "R10 period" : "R2 period", per, VEC[i][2]);
         end
      end

      // R3: field write without strobe
      wr(1'b0, mk(8, 1'b1, 1'b1, 1'b0, 1'b0));
      lock_wait(1'b0, j);
      wr(1'b0, mk(6, 1'b1, 1'b0, 1'b0, 1'b0));
      chk("R3 field stored", rd[11:4], 6);
      chk("R3 flag kept", rd[31], 1);
      measure(1'b0, hi, per);
      chk("R3 old period", per, 8);

      // R5: disable mid high phase, full pulse completes
      while (co !== 1'b0) @(negedge clk);
      while (co !== 1'b1) @(negedge clk);
      h = 1;
      wr(1'b0, mk(8, 1'b0, 1'b0, 1'b0, 1'b0));
      while (co === 1'b1 && h < 20) begin h++; @(negedge clk); end
      chk("R5 last pulse length", h, 4);
      for (int k = 0; k < 45; k++) begin
         if (co !== 1'b0) chk("R5 held low", co, 0);
         @(negedge clk);
      end
      chk("R5 low while off", co, 0);
      chk("R5 flag kept while off", rd[31], 1);
      wr(1'b0, mk(8, 1'b1, 1'b0, 1'b0, 1'b0));
      measure(1'b0, hi, per);
      chk("R5 first pulse full", hi, 4);
      chk("R5 period after enable", per, 8);

      // R6: domain reset
      wr(1'b0, mk(8, 1'b1, 1'b0, 1'b1, 1'b0));
      @(negedge clk);
      chk("R6 flag low", rd[31], 0);
      chk("R1 reset bit readback", rd[1], 1);
      h = 0;
      for (int k = 0; k < 30; k++) begin
         if (co === 1'b1) h++;
         @(negedge clk);
      end
      chk("R6 output low", h, 0);
      wr(1'b0, mk(8, 1'b1, 1'b0, 1'b0, 1'b0));
      lock_wait(1'b0, j);
      chk("R6 settle after release", j, 32);

      // R7: buffer gate
      wr(1'b0, mk(8, 1'b1, 1'b0, 1'b0, 1'b1));
      chk("R7 buffer off", bufen, 0);
      chk("R1 gate readback", rd[28], 1);
      wr(1'b0, mk(8, 1'b1, 1'b0, 1'b0, 1'b0));
      chk("R7 buffer on", bufen, 1);

      // R8 / R9: alternate instance
      wr(1'b1, mk(4, 1'b1, 1'b1, 1'b0, 1'b0));
      chk("R9 enable forced off", rd_a[0], 0);
      chk("R8 flag cleared", rd_a[27], 0);
      wr(1'b1, mk(4, 1'b1, 1'b0, 1'b0, 1'b0));
      chk("R9 enable ignored while pending", rd_a[0], 0);
      lock_wait(1'b1, j);
      chk("R8 settle count", j, 15);
      chk("R8 bit 31 clear", rd_a[31], 0);
      wr(1'b1, mk(4, 1'b1, 1'b0, 1'b0, 1'b0));
      chk("R9 enable accepted", rd_a[0], 1);
      measure(1'b1, hi, per);
      chk("R9 high", hi, 2);
      chk("R9 period", per, 4);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule